// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block receives programming words for a two-loop frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a load strobe. Bits enter a 23-bit shift register, most significant bit first. When the load strobe rises, the two bits shifted in last pick one of four destination latches: the reference divider of the IF loop, the programmable divider of the IF loop, the reference divider of the RF loop, or the programmable divider of the RF loop. The rest of the word is copied into that latch.

A reference latch holds a 14-bit divide value and four mode bits: prescaler ratio select, charge-pump current select, phase-detector polarity, and the select for the lock-detect or monitor output. A programmable latch holds a 7-bit swallow count and an 11-bit main count. Words carrying an out-of-range divide value are discarded. A one-cycle update strobe for each destination tells the downstream counters to reload.

The serial pins are sampled in the system clock domain. The block assumes they come from logic in that domain, or were synchronised before they reach it, and that they change more slowly than the system clock.

Top module: `synth_serial_loader`

## Requirements
- R1: After a synchronous active-low reset, every latched divide value and mode bit is zero and every update strobe is low.
- R2: On each system-clock edge where `ser_clk` is first seen high while `ser_le` is low, the register shifts left by one and takes `ser_data` into bit 0. Words are sent MSB first, so bits [1:0] of the word are the last two bits sent.
- R3: The address in bits [1:0] picks the destination: 00 is IF reference, 01 is IF programmable, 10 is RF reference and 11 is RF programmable. Only that destination's outputs may change.
- R4: In a reference word, bits [15:2] are the divide value, bit 16 is the prescaler select, bit 17 is the charge-pump current select, bit 18 is the phase polarity and bit 19 is the lock-detect output select. Bits [22:20] are ignored.
- R5: In a programmable word, bits [8:2] are the swallow count and bits [19:9] are the main count. Bits [22:20] are ignored.
- R6: A reference word whose divide value is below 3 is discarded. The latch keeps its old contents and no strobe is raised.
- R7: A programmable word whose main count is below 3 is discarded. The latch keeps its old contents and no strobe is raised.
- R8: Latched outputs change only on the edge where a rising `ser_le` is first seen. Holding `ser_le` high does not load again, and `ser_clk` edges while `ser_le` is high do not shift.
- R9: A load does not clear the shift register. A load after fewer than 23 new bits uses whatever the register holds at that moment.
- R10: An accepted load raises the update strobe of its destination for exactly one cycle, on the same edge where the outputs change. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| if_ref_div | output | 14 | IF reference divide value |
| if_presc_sel | output | 1 | IF prescaler ratio select |
| if_cp_sel | output | 1 | IF charge-pump current select |
| if_phase_pol | output | 1 | IF phase-detector polarity |
| if_ld_sel | output | 1 | IF lock-detect/monitor output select |
| if_swallow | output | 7 | IF swallow count |
| if_main | output | 11 | IF main count |
| if_ref_upd | output | 1 | IF reference latch updated strobe |
| if_prog_upd | output | 1 | IF programmable latch updated strobe |
| rf_ref_div | output | 14 | RF reference divide value |
| rf_presc_sel | output | 1 | RF prescaler ratio select |
| rf_cp_sel | output | 1 | RF charge-pump current select |
| rf_phase_pol | output | 1 | RF phase-detector polarity |
| rf_ld_sel | output | 1 | RF lock-detect/monitor output select |
| rf_swallow | output | 7 | RF swallow count |
| rf_main | output | 11 | RF main count |
| rf_ref_upd | output | 1 | RF reference latch updated strobe |
| rf_prog_upd | output | 1 | RF programmable latch updated strobe |

## Verification
The bench loads all four addresses with distinct patterns and sets the ignored top bits, so a decoder that swapped the loop bit with the kind bit, or that let the ignored bits leak into a field, would write the wrong latch or corrupt a value. It sends divide and main values of 2 and of exactly 3 to test the limits. A design that compared against the wrong limit would either latch the illegal value or reject the legal one. It holds the load strobe high while toggling the serial clock, which would expose a design that loads on the level or keeps shifting during a load. It then sends a two-bit partial word after a full one. A design that cleared the register on load would decode the wrong address and payload.

// File: rtl/sl_pkg.sv
// Package: shared constants and types for the serial synthesizer loader.
// Assumes a fixed two-loop (IF, RF) arrangement and the frame layout below.
package sl_pkg;
    localparam int FRAME_W  = 23;
    localparam int ADDR_W   = 2;
    localparam int REF_W    = 14;
    localparam int MODE_W   = 4;
    localparam int SWL_W    = 7;
    localparam int MAIN_W   = 11;
    localparam int N_LOOPS  = 2;
    localparam int REF_MIN  = 3;
    localparam int MAIN_MIN = 3;

    // Destination address: bit 1 picks the loop, bit 0 picks the latch kind.
    typedef enum logic [ADDR_W-1:0] {
        DST_IF_REF  = 2'b00,
        DST_IF_PROG = 2'b01,
        DST_RF_REF  = 2'b10,
        DST_RF_PROG = 2'b11
    } dest_e;

    // Mode bit positions inside the reference latch mode field.
    localparam int MODE_PRESC = 0;
    localparam int MODE_CP    = 1;
    localparam int MODE_PHASE = 2;
    localparam int MODE_LD    = 3;
endpackage

// File: rtl/sl_edge_detect.sv
// Module: sl_edge_detect
// Finds the rising edges of the serial clock and the load strobe in the
// system clock domain. Assumes both inputs are already synchronous to clk
// and stay at each level for at least one clk period.
module sl_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_le,
    output logic shift_en,
    output logic load_en
);
    logic sclk_q;
    logic le_q;

    // Keep the previous level of both serial control lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
            le_q   <= ser_le;
        end
    end

    // Shift on a serial clock rise only while no load is in progress.
    always_comb begin
        shift_en = ser_clk && !sclk_q && !ser_le;
        load_en  = ser_le && !le_q;
    end

    // R8: a load edge and a shift never occur together.
    a_r8_no_shift_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !shift_en);

    // R8: a load edge cannot repeat on consecutive cycles.
    a_r8_single_load_edge: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);
endmodule

// File: rtl/sl_shift_reg.sv
// Module: sl_shift_reg
// Serial-in parallel-out frame register, MSB first. A load does not clear
// it, so partial frames reuse older bits.
module sl_shift_reg #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Shift one bit in at the LSB on each qualified serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[W-2:0], din};
        end
    end

    // R9: the register holds its contents whenever no shift is requested.
    a_r9_hold_without_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q));
endmodule

// File: rtl/sl_frame_decode.sv
// Module: sl_frame_decode
// Splits the frame into fields, decodes the address and decides whether a
// load is legal. Produces one write enable per destination latch.
module sl_frame_decode
    import sl_pkg::*;
#(
    parameter int FW       = FRAME_W,
    parameter int RW       = REF_W,
    parameter int MW       = MODE_W,
    parameter int SW       = SWL_W,
    parameter int NW       = MAIN_W,
    parameter int LOOPS    = N_LOOPS,
    parameter int RMIN     = REF_MIN,
    parameter int NMIN     = MAIN_MIN
) (
    input  logic [FW-1:0]    frame,
    input  logic             load_en,
    output logic [LOOPS-1:0] ref_we,
    output logic [LOOPS-1:0] prog_we,
    output logic [RW-1:0]    ref_div,
    output logic [MW-1:0]    ref_mode,
    output logic [SW-1:0]    swallow,
    output logic [NW-1:0]    main_cnt
);
    localparam int REF_LSB  = ADDR_W;
    localparam int MODE_LSB = REF_LSB + RW;
    localparam int SWL_LSB  = ADDR_W;
    localparam int MAIN_LSB = SWL_LSB + SW;

    dest_e addr;
    logic  is_prog;
    logic  loop_sel;
    logic  ref_ok;
    logic  main_ok;

    // Extract the address and both possible payload layouts.
    always_comb begin
        addr     = dest_e'(frame[ADDR_W-1:0]);
        is_prog  = frame[0];
        loop_sel = frame[1];
        ref_div  = frame[REF_LSB +: RW];
        ref_mode = frame[MODE_LSB +: MW];
        swallow  = frame[SWL_LSB +: SW];
        main_cnt = frame[MAIN_LSB +: NW];
        ref_ok   = ref_div >= RW'(RMIN);
        main_ok  = main_cnt >= NW'(NMIN);
    end

    // Raise the write enable of exactly the addressed latch when legal.
    always_comb begin
        for (int i = 0; i < LOOPS; i++) begin
            ref_we[i]  = load_en && !is_prog && (loop_sel == i[0]) && ref_ok;
            prog_we[i] = load_en &&  is_prog && (loop_sel == i[0]) && main_ok;
        end
    end

    // R3: at most one destination is written per load.
    a_r3_one_destination: assert property (@(posedge load_en)
        $onehot0({ref_we, prog_we}));
endmodule

// File: rtl/sl_ref_latch.sv
// Module: sl_ref_latch
// Reference divider latch of one loop: divide value and mode bits, plus a
// registered strobe raised on the cycle the latch takes new contents.
module sl_ref_latch #(
    parameter int RW   = 14,
    parameter int MW   = 4,
    parameter int RMIN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] div_in,
    input  logic [MW-1:0] mode_in,
    output logic [RW-1:0] div_q,
    output logic [MW-1:0] mode_q,
    output logic          upd
);
    // Capture the payload on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            mode_q <= '0;
        end else if (we) begin
            div_q  <= div_in;
            mode_q <= mode_in;
        end
    end

    // Flag the reload for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= we;
    end

    // R6: an illegal divide value never reaches the latch.
    a_r6_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) || (div_q >= RW'(RMIN)));

    // R8: contents stay put without a write.
    a_r8_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(div_q) && $stable(mode_q)));

    // R10: the strobe lasts a single cycle.
    a_r10_ref_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);
endmodule

// File: rtl/sl_prog_latch.sv
// Module: sl_prog_latch
// Programmable divider latch of one loop: swallow and main counts, plus a
// registered strobe raised on the cycle the latch takes new contents.
module sl_prog_latch #(
    parameter int SW   = 7,
    parameter int NW   = 11,
    parameter int NMIN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] swl_in,
    input  logic [NW-1:0] main_in,
    output logic [SW-1:0] swl_q,
    output logic [NW-1:0] main_q,
    output logic          upd
);
    // Capture both counts on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swl_q  <= '0;
            main_q <= '0;
        end else if (we) begin
            swl_q  <= swl_in;
            main_q <= main_in;
        end
    end

    // Flag the reload for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= we;
    end

    // R7: an illegal main count never reaches the latch.
    a_r7_main_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (main_q == '0) || (main_q >= NW'(NMIN)));

    // R8: contents stay put without a write.
    a_r8_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(swl_q) && $stable(main_q)));

    // R10: the strobe lasts a single cycle.
    a_r10_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);
endmodule

// File: rtl/synth_serial_loader.sv
// Module: synth_serial_loader
// Three-wire programming interface of a two-loop synthesizer: shifts in a
// 23-bit frame and steers it into one of four latches on the load edge.
// Assumes the serial pins are synchronous to clk and slower than it.
module synth_serial_loader
    import sl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  if_ref_div,
    output logic              if_presc_sel,
    output logic              if_cp_sel,
    output logic              if_phase_pol,
    output logic              if_ld_sel,
    output logic [SWL_W-1:0]  if_swallow,
    output logic [MAIN_W-1:0] if_main,
    output logic              if_ref_upd,
    output logic              if_prog_upd,
    output logic [REF_W-1:0]  rf_ref_div,
    output logic              rf_presc_sel,
    output logic              rf_cp_sel,
    output logic              rf_phase_pol,
    output logic              rf_ld_sel,
    output logic [SWL_W-1:0]  rf_swallow,
    output logic [MAIN_W-1:0] rf_main,
    output logic              rf_ref_upd,
    output logic              rf_prog_upd
);
    logic                 shift_en;
    logic                 load_en;
    logic [FRAME_W-1:0]   frame;
    logic [N_LOOPS-1:0]   ref_we;
    logic [N_LOOPS-1:0]   prog_we;
    logic [REF_W-1:0]     dec_div;
    logic [MODE_W-1:0]    dec_mode;
    logic [SWL_W-1:0]     dec_swl;
    logic [MAIN_W-1:0]    dec_main;

    logic [REF_W-1:0]     div_arr  [N_LOOPS];
    logic [MODE_W-1:0]    mode_arr [N_LOOPS];
    logic [SWL_W-1:0]     swl_arr  [N_LOOPS];
    logic [MAIN_W-1:0]    main_arr [N_LOOPS];
    logic [N_LOOPS-1:0]   ref_upd;
    logic [N_LOOPS-1:0]   prog_upd;

    sl_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_le   (ser_le),
        .shift_en (shift_en),
        .load_en  (load_en)
    );

    sl_shift_reg #(.W(FRAME_W)) u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (ser_data),
        .q        (frame)
    );

    sl_frame_decode u_dec (
        .frame    (frame),
        .load_en  (load_en),
        .ref_we   (ref_we),
        .prog_we  (prog_we),
        .ref_div  (dec_div),
        .ref_mode (dec_mode),
        .swallow  (dec_swl),
        .main_cnt (dec_main)
    );

    // One reference and one programmable latch per loop.
    for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
        sl_ref_latch #(.RW(REF_W), .MW(MODE_W), .RMIN(REF_MIN)) u_ref (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (ref_we[g]),
            .div_in  (dec_div),
            .mode_in (dec_mode),
            .div_q   (div_arr[g]),
            .mode_q  (mode_arr[g]),
            .upd     (ref_upd[g])
        );

        sl_prog_latch #(.SW(SWL_W), .NW(MAIN_W), .NMIN(MAIN_MIN)) u_prog (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (prog_we[g]),
            .swl_in  (dec_swl),
            .main_in (dec_main),
            .swl_q   (swl_arr[g]),
            .main_q  (main_arr[g]),
            .upd     (prog_upd[g])
        );
    end

    // Map loop 0 to the IF outputs and loop 1 to the RF outputs.
    always_comb begin
        if_ref_div   = div_arr[0];
        if_presc_sel = mode_arr[0][MODE_PRESC];
        if_cp_sel    = mode_arr[0][MODE_CP];
        if_phase_pol = mode_arr[0][MODE_PHASE];
        if_ld_sel    = mode_arr[0][MODE_LD];
        if_swallow   = swl_arr[0];
        if_main      = main_arr[0];
        if_ref_upd   = ref_upd[0];
        if_prog_upd  = prog_upd[0];
        rf_ref_div   = div_arr[1];
        rf_presc_sel = mode_arr[1][MODE_PRESC];
        rf_cp_sel    = mode_arr[1][MODE_CP];
        rf_phase_pol = mode_arr[1][MODE_PHASE];
        rf_ld_sel    = mode_arr[1][MODE_LD];
        rf_swallow   = swl_arr[1];
        rf_main      = main_arr[1];
        rf_ref_upd   = ref_upd[1];
        rf_prog_upd  = prog_upd[1];
    end

    // R2: the newest serial bit lands in bit 0 after a qualified edge.
    a_r2_shift_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (frame[0] == $past(ser_data)));

    // R10: no two destinations report an update together.
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({if_ref_upd, if_prog_upd, rf_ref_upd, rf_prog_upd}));

    // R8: a strobe only follows a load edge seen on the previous cycle.
    a_r8_strobe_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> !(if_ref_upd || if_prog_upd || rf_ref_upd || rf_prog_upd));
endmodule

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;

    logic [13:0] if_ref_div, rf_ref_div;
    logic [6:0]  if_swallow, rf_swallow;
    logic [10:0] if_main, rf_main;
    logic if_presc_sel, if_cp_sel, if_phase_pol, if_ld_sel, if_ref_upd, if_prog_upd;
    logic rf_presc_sel, rf_cp_sel, rf_phase_pol, rf_ld_sel, rf_ref_upd, rf_prog_upd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model of the shift register and the four latches.
    logic [22:0] m_sreg = '0;
    logic [13:0] m_div  [2];
    logic [3:0]  m_mode [2];
    logic [6:0]  m_swl  [2];
    logic [10:0] m_main [2];

    always #4 clk = ~clk;

    synth_serial_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .if_ref_div(if_ref_div), .if_presc_sel(if_presc_sel), .if_cp_sel(if_cp_sel),
        .if_phase_pol(if_phase_pol), .if_ld_sel(if_ld_sel), .if_swallow(if_swallow),
        .if_main(if_main), .if_ref_upd(if_ref_upd), .if_prog_upd(if_prog_upd),
        .rf_ref_div(rf_ref_div), .rf_presc_sel(rf_presc_sel), .rf_cp_sel(rf_cp_sel),
        .rf_phase_pol(rf_phase_pol), .rf_ld_sel(rf_ld_sel), .rf_swallow(rf_swallow),
        .rf_main(rf_main), .rf_ref_upd(rf_ref_upd), .rf_prog_upd(rf_prog_upd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {rf_prog_upd, rf_ref_upd, if_prog_upd, if_ref_upd};
    endfunction

    // R4 layout: [19] ld, [18] phase, [17] cp, [16] presc, [15:2] div, [1:0] addr.
    function automatic logic [22:0] mk_ref(input logic [2:0] junk, input logic [3:0] mode,
                                           input logic [13:0] div, input logic rf);
        return {junk, mode, div, rf, 1'b0};
    endfunction

    // R5 layout: [19:9] main, [8:2] swallow, [1:0] addr.
    function automatic logic [22:0] mk_prog(input logic [2:0] junk, input logic [10:0] mn,
                                            input logic [6:0] sw, input logic rf);
        return {junk, mn, sw, rf, 1'b1};
    endfunction

    // Compare every latched output against the model.
    task automatic chk_all(input string req);
        chk({req, " if_div"},  32'(if_ref_div), 32'(m_div[0]));
        chk({req, " if_mode"}, 32'({if_ld_sel, if_phase_pol, if_cp_sel, if_presc_sel}), 32'(m_mode[0]));
        chk({req, " if_swl"},  32'(if_swallow), 32'(m_swl[0]));
        chk({req, " if_main"}, 32'(if_main),    32'(m_main[0]));
        chk({req, " rf_div"},  32'(rf_ref_div), 32'(m_div[1]));
        chk({req, " rf_mode"}, 32'({rf_ld_sel, rf_phase_pol, rf_cp_sel, rf_presc_sel}), 32'(m_mode[1]));
        chk({req, " rf_swl"},  32'(rf_swallow), 32'(m_swl[1]));
        chk({req, " rf_main"}, 32'(rf_main),    32'(m_main[1]));
    endtask

    // One serial bit; shifts the model only when the load strobe is low (R2, R8).
    task automatic send_bit(input logic b);
        @(negedge clk); ser_data = b; ser_clk = 1'b0;
        @(negedge clk); ser_clk = 1'b1;
        if (!ser_le) m_sreg = {m_sreg[21:0], b};
        @(negedge clk); ser_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [22:0] f);
        for (int i = 22; i >= 0; i--) send_bit(f[i]);
    endtask

    // Raise the load strobe, check strobes and outputs, then drop it (R3, R8, R10).
    task automatic do_load(input string req, input bit hold_high);
        logic [3:0] exp_str;
        logic [1:0] a;
        a = m_sreg[1:0];
        exp_str = '0;
        if (!a[0]) begin
            if (m_sreg[15:2] >= 14'd3) begin
                m_div[a[1]]  = m_sreg[15:2];
                m_mode[a[1]] = m_sreg[19:16];
                exp_str = 4'b1 << a;
            end
        end else begin
            if (m_sreg[19:9] >= 11'd3) begin
                m_swl[a[1]]  = m_sreg[8:2];
                m_main[a[1]] = m_sreg[19:9];
                exp_str = 4'b1 << a;
            end
        end
        @(negedge clk); ser_le = 1'b1;
        @(posedge clk); #1;
        chk({req, " R10 strobe"}, 32'(strobes()), 32'(exp_str));
        chk_all(req);
        @(posedge clk); #1;
        chk({req, " R10 strobe drops"}, 32'(strobes()), 32'h0);
        if (!hold_high) begin
            @(negedge clk); ser_le = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) begin
            m_div[i] = '0; m_mode[i] = '0; m_swl[i] = '0; m_main[i] = '0;
        end
        m_sreg = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset strobes", 32'(strobes()), 32'h0);
        chk_all("R1 reset");
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_all_addresses();
        send_frame(mk_ref(3'b111, 4'b1010, 14'd1234, 1'b0));
        do_load("R3 R4 IF-ref", 0);
        send_frame(mk_prog(3'b101, 11'd2047, 7'd127, 1'b0));
        do_load("R3 R5 IF-prog", 0);
        send_frame(mk_ref(3'b010, 4'b0101, 14'd16383, 1'b1));
        do_load("R3 R4 RF-ref", 0);
        send_frame(mk_prog(3'b000, 11'd600, 7'd33, 1'b1));
        do_load("R3 R5 RF-prog", 0);
        send_frame(mk_ref(3'b000, 4'b1111, 14'h2AAA, 1'b0));
        do_load("R2 R4 IF-ref pattern", 0);
    endtask

    task automatic t_limits();
        send_frame(mk_ref(3'b000, 4'b1111, 14'd2, 1'b1));
        do_load("R6 RF-ref div 2 rejected", 0);
        send_frame(mk_ref(3'b000, 4'b0011, 14'd3, 1'b1));
        do_load("R6 RF-ref div 3 accepted", 0);
        send_frame(mk_prog(3'b000, 11'd2, 7'd9, 1'b0));
        do_load("R7 IF-prog main 2 rejected", 0);
        send_frame(mk_prog(3'b000, 11'd0, 7'd9, 1'b1));
        do_load("R7 RF-prog main 0 rejected", 0);
        send_frame(mk_prog(3'b000, 11'd3, 7'd0, 1'b0));
        do_load("R7 IF-prog main 3 accepted", 0);
    endtask

    task automatic t_hold_le();
        send_frame(mk_prog(3'b000, 11'd777, 7'd5, 1'b1));
        do_load("R8 first load", 1);
        // Serial edges with the strobe held high must not shift.
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        repeat (4) @(posedge clk);
        #1;
        chk("R8 no reload while held", 32'(strobes()), 32'h0);
        chk_all("R8 held");
        @(negedge clk); ser_le = 1'b0;
        do_load("R8 R9 reload unchanged frame", 0);
    endtask

    task automatic t_short_frame();
        send_frame(mk_prog(3'b000, 11'd1500, 7'd77, 1'b1));
        do_load("R9 full frame", 0);
        send_bit(1'b0); send_bit(1'b0);
        do_load("R9 two-bit partial frame", 0);
    endtask

    initial begin
        t_reset();
        t_all_addresses();
        t_limits();
        t_hold_le();
        t_short_frame();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule